// File: doc/BRIEF.md
# Processor Cycle Counter Register

This block holds a 64-bit cycle count register for a processor core. The lower 32 bits form a counter that advances by one on every clock while a counting enable is set. The upper 32 bits have no counting behaviour. They are storage that software uses as an offset, so that a per-process count can be derived from the shared counter.

Software reaches the block through one write bus that carries a write strobe, a register index and 64 bits of data. One index writes the offset half and leaves the running count alone. A second index is a write-only control register. Writing it reloads the counter (with its four lowest bits forced to zero) and turns counting on or off. The read port always presents the whole 64-bit value.

Top module: `cycle_count_reg`

## Requirements
- R1: After reset the read value is zero and the counter is disabled, so it stays zero until a control write enables it.
- R2: While enabled, and with no control write in the same cycle, the low half of the read value grows by exactly one per clock.
- R3: While disabled, the low half holds its value from cycle to cycle.
- R4: A write with index 0x10 (offset register) loads read bits 63:32 from write-data bits 63:32. The count and the enable are not changed by it, so a running count keeps advancing through that cycle.
- R5: A write with index 0x11 (control register) sets count bits 31:4 from write-data bits 31:4, clears count bits 3:0, and sets the enable from write-data bit 32. Write-data bits 63:33 and 3:0 are ignored, and the offset half is unchanged.
- R6: When a control write and an increment fall in the same cycle, the written value wins and no increment is applied in that cycle. Counting resumes from the written value on the next clock if enabled.
- R7: The low half wraps from 0xFFFFFFFF to 0x00000000 with no carry into the offset half.
- R8: The read port shows {offset, count} as held in the registers. A read in the same cycle as a write returns the value from before that write.
- R9: Write cycles with the strobe low, or with any index other than 0x10 or 0x11, change neither the count, the offset nor the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the counter steps on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 8 | Register index of the write (0x10 offset, 0x11 control) |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Current register value, offset in 63:32 and count in 31:0 |

## Verification
The bench fires a control write in a cycle where the counter would also increment. A design that let the increment win, or added it on top of the load, would end one count too high. It loads a value with nonzero low bits, with ones in the ignored upper data bits and with a set enable bit. This catches a load that keeps bits 3:0 or a decode that lets bits 63:33 reach the offset. It writes the offset while the counter runs, which exposes a design that stalls or reloads the count on an offset write. It drives the counter across its 32-bit limit, where a carry leaking into the offset would show at once. It also sends writes with the strobe low or with a foreign index, to catch a loose index decode.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  // Per-cycle commands from the control module to the datapath
  typedef struct packed {
    logic loadOffset;  // take the offset half from write data
    logic loadCount;   // reload the counter from write data
    logic incr;        // advance the counter by one
  } ccrStrobe_t;

endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter logic [IDX_W-1:0] OFFSET_IDX = 8'h10,
  parameter logic [IDX_W-1:0] CTRL_IDX   = 8'h11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             enaIn,
  output ccrStrobe_t       strobe
);

  logic hitOffset;
  logic hitCtrl;
  logic enaQ;

  assign hitOffset = wrEn && (wrIdx == OFFSET_IDX);
  assign hitCtrl   = wrEn && (wrIdx == CTRL_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enaQ <= 1'b0;
    end else if (hitCtrl) begin
      enaQ <= enaIn;
    end
  end

  // A control write takes the cycle; no increment alongside it
  always_comb begin
    strobe.loadOffset = hitOffset;
    strobe.loadCount  = hitCtrl;
    strobe.incr       = enaQ && !hitCtrl;
  end

  // R9
  load_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadOffset, strobe.loadCount}));

  // R5
  ena_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitCtrl |=> (enaQ == $past(enaIn)));

  // R4
  ena_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitCtrl |=> $stable(enaQ));

  // R6
  no_incr_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |-> !strobe.incr);

endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int OFF_W    = 32,
  parameter int LOAD_LSB = 4,
  localparam int DATA_W  = CNT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countQ,
  output logic [OFF_W-1:0]  offsetQ
);

  localparam logic [LOAD_LSB-1:0] LOW_ZERO = '0;

  logic [CNT_W-1:0] loadVal;
  logic             unusedLowBits;

  assign loadVal       = {wrData[CNT_W-1:LOAD_LSB], LOW_ZERO};
  assign unusedLowBits = ^wrData[LOAD_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= loadVal;
    end else if (strobe.incr) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
    end else if (strobe.loadOffset) begin
      offsetQ <= wrData[DATA_W-1:CNT_W];
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.loadCount) |=> (countQ == $past(countQ) + CNT_W'(1)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incr && !strobe.loadCount) |=> $stable(countQ));

  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> (countQ[LOAD_LSB-1:0] == LOW_ZERO) &&
      (countQ[CNT_W-1:LOAD_LSB] == $past(wrData[CNT_W-1:LOAD_LSB])));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.loadCount && !strobe.loadOffset && (&countQ))
      |=> (countQ == '0) && $stable(offsetQ));

  // R4
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOffset |=> $stable(offsetQ));

endmodule

// File: rtl/cycle_count_reg.sv
module cycle_count_reg
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 8,
  parameter int LOAD_LSB = 4,
  parameter logic [IDX_W-1:0] OFFSET_IDX = 8'h10,
  parameter logic [IDX_W-1:0] CTRL_IDX   = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int CNT_W   = DATA_W / 2;
  localparam int OFF_W   = DATA_W - CNT_W;
  localparam int ENA_BIT = CNT_W;

  ccrStrobe_t       strobe;
  logic [CNT_W-1:0] countQ;
  logic [OFF_W-1:0] offsetQ;

  ccr_ctrl #(
    .IDX_W      (IDX_W),
    .OFFSET_IDX (OFFSET_IDX),
    .CTRL_IDX   (CTRL_IDX)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .enaIn  (wrData[ENA_BIT]),
    .strobe (strobe)
  );

  ccr_datapath #(
    .CNT_W    (CNT_W),
    .OFF_W    (OFF_W),
    .LOAD_LSB (LOAD_LSB)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .countQ  (countQ),
    .offsetQ (offsetQ)
  );

  assign rdData = {offsetQ, countQ};

endmodule

// File: tb/test_cycle_count_reg.sv
`timescale 1ns/1ps
module test_cycle_count_reg;

  localparam logic [7:0] IDX_OFF  = 8'h10;
  localparam logic [7:0] IDX_CTRL = 8'h11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cycle_count_reg i_cycle_count_reg (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .rdData (rdData)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [7:0] idx, input logic [63:0] data);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    run(1);
    wrEn = 1'b0; wrData = '0; wrIdx = '0;
  endtask

  task automatic testReset();
    run(3);
    check("R1 in reset", rdData, 64'h0);
    rstN = 1'b1;
    run(6);
    check("R1 disabled after reset", rdData, 64'h0);
  endtask

  task automatic testCtrlLoad();
    // ignored upper bits set, enable bit 32 set, low nibble nonzero
    doWrite(IDX_CTRL, {31'h7FFF_FFFF, 1'b1, 32'h1234_567F});
    check("R5 load clears low bits", rdData, {32'h0, 32'h1234_5670});
    run(10);
    check("R2 counts by one", rdData, {32'h0, 32'h1234_567A});
  endtask

  task automatic testOffset();
    wrEn = 1'b1; wrIdx = IDX_OFF; wrData = {32'hDEAD_BEEF, 32'h0000_1111};
    #0.5;
    check("R8 read before write lands", rdData, {32'h0, 32'h1234_567A});
    run(1);
    wrEn = 1'b0; wrData = '0;
    check("R4 offset written, count runs", rdData, {32'hDEAD_BEEF, 32'h1234_567B});
    run(2);
    check("R4 enable kept", rdData, {32'hDEAD_BEEF, 32'h1234_567D});
  endtask

  task automatic testDisable();
    doWrite(IDX_CTRL, 64'hFFFF_FFFE_0000_0ABC);
    check("R5 disable load", rdData, {32'hDEAD_BEEF, 32'h0000_0AB0});
    run(5);
    check("R3 holds while disabled", rdData, {32'hDEAD_BEEF, 32'h0000_0AB0});
  endtask

  task automatic testIgnored();
    wrIdx = IDX_CTRL; wrData = 64'h0000_0001_5555_5550; wrEn = 1'b0;
    run(2);
    check("R9 strobe low ignored", rdData, {32'hDEAD_BEEF, 32'h0000_0AB0});
    doWrite(8'h12, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3);
    check("R9 foreign index ignored", rdData, {32'hDEAD_BEEF, 32'h0000_0AB0});
  endtask

  task automatic testCollide();
    doWrite(IDX_CTRL, 64'h0000_0001_0000_0200);
    run(3);
    check("R2 counting from load", rdData, {32'hDEAD_BEEF, 32'h0000_0203});
    doWrite(IDX_CTRL, 64'h0000_0001_0000_0105);
    check("R6 load beats increment", rdData, {32'hDEAD_BEEF, 32'h0000_0100});
    run(1);
    check("R6 resumes after load", rdData, {32'hDEAD_BEEF, 32'h0000_0101});
  endtask

  task automatic testWrap();
    doWrite(IDX_CTRL, 64'h0000_0001_FFFF_FFF5);
    run(15);
    check("R7 at top", rdData, {32'hDEAD_BEEF, 32'hFFFF_FFFF});
    run(1);
    check("R7 wraps without carry", rdData, {32'hDEAD_BEEF, 32'h0000_0000});
    run(1);
    check("R7 continues after wrap", rdData, {32'hDEAD_BEEF, 32'h0000_0001});
  endtask

  initial begin
    #1;
    testReset();
    testCtrlLoad();
    testOffset();
    testDisable();
    testIgnored();
    testCollide();
    testWrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule